// File: doc/BRIEF.md
# Processor-Cycle to Synchronous Backplane Bridge

This block connects an 8-bit microprocessor, whose bus cycle is framed by a single clock phase signal, to a backplane bus that runs on its own synchronous clock (25 MHz nominal). The phase signal is brought into the bus clock domain through a flip-flop synchroniser. Each rising edge of the synchronised phase starts one bus transaction. The bridge places the processor address on the backplane and raises a read or write strobe. For writes it also presents the processor's data. It then waits for the target to signal completion.

For a read, the bridge holds the returned byte on the processor data lines until the phase signal falls, so the processor samples it cleanly. The read strobe and the address therefore stay valid in the final state. The write strobe is dropped there, because a repeated write would corrupt FIFOs and clear-on-write registers. The backplane interrupt request is passed to the processor as an active-low line.

A four-state controller {s1,s0} sequences each transaction, using the codes IDLE=00, DRIVE=01, WAIT=11, DONE=10. The upper address byte is a fixed slot code taken from a parameter.

Top module: `cpu_bus_bridge`

## Requirements
- R1: While synchronous reset is active, and on the first cycle after it, the controller is in IDLE. In that state `path_oe_n`=1, both strobes are 0, `bus_addr`=0, `bus_wdata`=0 and `cpu_doe`=0.
- R2: A rising edge of `cpu_phi2` that is set up before clock edge E0 leaves the bridge idle after edge E1. Only after edge E2 does the bridge show an active transaction.
- R3: DRIVE always moves to WAIT on the next edge. WAIT holds, with strobe and enables unchanged, for as long as `bus_ready` is 0. WAIT moves to DONE on the edge where `bus_ready` is 1.
- R4: DONE holds while the synchronised phase is high. After `cpu_phi2` falls, the bridge returns to IDLE on the third clock edge, with strobes low and `path_oe_n`=1.
- R5: `path_oe_n` is 0 exactly in DRIVE, WAIT and DONE, and 1 in IDLE.
- R6: For a read (`cpu_rw`=1), `bus_rstrb` is 1 in DRIVE, WAIT and DONE.
- R7: For a write (`cpu_rw`=0), `bus_wstrb` is 1 in DRIVE and WAIT only. It is never 1 in DONE or IDLE, and never 1 for a read.
- R8: During a write transaction, `bus_wdata` equals `cpu_din`.
- R9: During a read transaction, `cpu_doe`=1 and `cpu_dout` equals `bus_rdata`, including in DONE. During a write, `cpu_doe`=0.
- R10: While a transaction is active, `bus_addr[15:0]` equals `cpu_addr` and `bus_addr[23:16]` equals the slot parameter. The default slot code is 0x40, and 0x40 to 0x4F select slots 0 to 15.
- R11: `cpu_irq_n` is always the inverse of `bus_irq`.
- R12: `bus_ready` asserted while the bridge is idle starts nothing. `path_oe_n` stays 1 and both strobes stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 16 | Processor address |
| cpu_rw | input | 1 | Direction: 1 = read, 0 = write |
| cpu_phi2 | input | 1 | Processor phase clock, asynchronous to clk |
| cpu_din | input | 8 | Data driven by the processor on writes |
| cpu_dout | output | 8 | Read data returned to the processor |
| cpu_doe | output | 1 | Enables `cpu_dout` onto the processor data lines |
| cpu_irq_n | output | 1 | Active-low interrupt to the processor |
| bus_addr | output | 24 | Backplane address: slot code and processor address |
| bus_wdata | output | 8 | Backplane write data |
| bus_rdata | input | 8 | Backplane read data from the target |
| bus_wstrb | output | 1 | Write strobe |
| bus_rstrb | output | 1 | Read strobe |
| bus_ready | input | 1 | Target completion |
| bus_irq | input | 1 | Backplane interrupt request, active high |
| path_oe_n | output | 1 | Shared active-low enable for the address and data buffers |

## Verification
The hardest situation to reach is DONE on a read while the processor phase is still high. In that state the read strobe, the address and the returned byte must all stay valid, while the write strobe must not reappear. The port pattern is identical to WAIT, so the two states cannot be told apart directly. The stimulus therefore holds `cpu_phi2` high for extra cycles after `bus_ready` has been pulsed for exactly one cycle. It then lowers the phase and counts the edges until the enable releases. A table of back-to-back writes and reads, with varied completion delays, checks that each written byte returns from the bench's target model.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_DRIVE = 2'b01,
        ST_WAIT  = 2'b11,
        ST_DONE  = 2'b10
    } bstate_t;

    typedef struct packed {
        bstate_t st;
    } fsm_regs_t;

    localparam fsm_regs_t FSM_RESET = '{st: ST_IDLE};

endpackage

// File: rtl/phi_sync.sv
module phi_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phi_raw,
    output logic phi_level,
    output logic phi_rise
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_regs_t;

    sync_regs_t r_q, r_d;

    always_comb begin
        r_d          = r_q;
        r_d.chain[0] = phi_raw;
        for (int i = 1; i < int'(STAGES); i++) begin
            r_d.chain[i] = r_q.chain[i-1];
        end
        r_d.prev = r_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign phi_level = r_q.chain[STAGES-1];
    assign phi_rise  = r_q.chain[STAGES-1] & ~r_q.prev;

endmodule

// File: rtl/bridge_fsm.sv
module bridge_fsm
    import bridge_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    phi_level,
    input  logic    phi_rise,
    input  logic    bus_ready,
    output bstate_t state
);

    fsm_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE:  if (phi_rise)   r_d.st = ST_DRIVE;
            ST_DRIVE:                 r_d.st = ST_WAIT;
            ST_WAIT:  if (bus_ready)  r_d.st = ST_DONE;
            ST_DONE:  if (!phi_level) r_d.st = ST_IDLE;
            default:                  r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= FSM_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.st;

endmodule

// File: rtl/bridge_paths.sv
module bridge_paths
    import bridge_pkg::*;
#(
    parameter int unsigned CPU_AW = 16,
    parameter int unsigned BUS_AW = 24,
    parameter int unsigned DW     = 8,
    parameter int unsigned BANK   = 'h40
) (
    input  bstate_t           state,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic [DW-1:0]     cpu_din,
    input  logic [DW-1:0]     bus_rdata,
    input  logic              bus_irq,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [DW-1:0]     bus_wdata,
    output logic              bus_wstrb,
    output logic              bus_rstrb,
    output logic [DW-1:0]     cpu_dout,
    output logic              cpu_doe,
    output logic              path_oe_n,
    output logic              cpu_irq_n
);

    localparam int unsigned BANK_W = BUS_AW - CPU_AW;
    localparam logic [BANK_W-1:0] BANK_V = BANK_W'(BANK);

    logic s0, s1, data_hot;

    always_comb begin
        s0        = state[0];
        s1        = state[1];
        data_hot  = s0 | s1;
        path_oe_n = ~data_hot;
        bus_wstrb = s0 & ~cpu_rw;
        bus_rstrb = data_hot & cpu_rw;
        bus_addr  = data_hot ? {BANK_V, cpu_addr} : '0;
        bus_wdata = (data_hot & ~cpu_rw) ? cpu_din : '0;
        cpu_doe   = data_hot & cpu_rw;
        cpu_dout  = (data_hot & cpu_rw) ? bus_rdata : '0;
        cpu_irq_n = ~bus_irq;
    end

endmodule

// File: rtl/cpu_bus_bridge.sv
module cpu_bus_bridge
    import bridge_pkg::*;
#(
    parameter int unsigned CPU_AW      = 16,
    parameter int unsigned BUS_AW      = 24,
    parameter int unsigned DW          = 8,
    parameter int unsigned BANK        = 'h40,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic              cpu_phi2,
    input  logic [DW-1:0]     cpu_din,
    output logic [DW-1:0]     cpu_dout,
    output logic              cpu_doe,
    output logic              cpu_irq_n,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata,
    output logic              bus_wstrb,
    output logic              bus_rstrb,
    input  logic              bus_ready,
    input  logic              bus_irq,
    output logic              path_oe_n
);

    logic    phi_level;
    logic    phi_rise;
    bstate_t state_q;

    phi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .phi_raw   (cpu_phi2),
        .phi_level (phi_level),
        .phi_rise  (phi_rise)
    );

    bridge_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .phi_level (phi_level),
        .phi_rise  (phi_rise),
        .bus_ready (bus_ready),
        .state     (state_q)
    );

    bridge_paths #(
        .CPU_AW (CPU_AW),
        .BUS_AW (BUS_AW),
        .DW     (DW),
        .BANK   (BANK)
    ) u_paths (
        .state     (state_q),
        .cpu_addr  (cpu_addr),
        .cpu_rw    (cpu_rw),
        .cpu_din   (cpu_din),
        .bus_rdata (bus_rdata),
        .bus_irq   (bus_irq),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wstrb (bus_wstrb),
        .bus_rstrb (bus_rstrb),
        .cpu_dout  (cpu_dout),
        .cpu_doe   (cpu_doe),
        .path_oe_n (path_oe_n),
        .cpu_irq_n (cpu_irq_n)
    );

endmodule

// File: rtl/bridge_chk.sv
module bridge_chk
    import bridge_pkg::*;
#(
    parameter int unsigned BUS_AW = 24,
    parameter int unsigned BANK_W = 8,
    parameter int unsigned BANK   = 'h40
) (
    input logic              clk,
    input logic              rst_n,
    input bstate_t           state_q,
    input logic              phi_level,
    input logic              phi_rise,
    input logic              bus_ready,
    input logic              bus_wstrb,
    input logic              bus_rstrb,
    input logic              cpu_rw,
    input logic              cpu_doe,
    input logic              path_oe_n,
    input logic [BUS_AW-1:0] bus_addr
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> state_q == ST_IDLE);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !phi_rise) |=> state_q == ST_IDLE);

    // R3
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !bus_ready) |=> state_q == ST_WAIT);

    // R4
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && phi_level) |=> state_q == ST_DONE);

    // R5
    strobe_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wstrb || bus_rstrb) |-> !path_oe_n);

    // R6
    done_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && cpu_rw) |-> bus_rstrb);

    // R7
    no_write_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DONE |-> !bus_wstrb);

    // R9
    read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rstrb |-> cpu_doe);

    // R10
    slot_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rstrb |-> bus_addr[BUS_AW-1 -: BANK_W] == BANK_W'(BANK));

endmodule

bind cpu_bus_bridge bridge_chk #(
    .BUS_AW (BUS_AW),
    .BANK_W (BUS_AW - CPU_AW),
    .BANK   (BANK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .phi_level (phi_level),
    .phi_rise  (phi_rise),
    .bus_ready (bus_ready),
    .bus_wstrb (bus_wstrb),
    .bus_rstrb (bus_rstrb),
    .cpu_rw    (cpu_rw),
    .cpu_doe   (cpu_doe),
    .path_oe_n (path_oe_n),
    .bus_addr  (bus_addr)
);

// File: tb/sim_cpu_bus_bridge.sv
module sim_cpu_bus_bridge;

    localparam logic [7:0] SLOT = 8'h40;
    localparam int NVEC = 8;
    // {rw, addr[15:0], data[7:0], delay[3:0]}
    localparam logic [28:0] VEC [NVEC] = '{
        {1'b0, 16'h1234, 8'hA5, 4'd0},
        {1'b0, 16'hFF00, 8'h3C, 4'd2},
        {1'b1, 16'h1234, 8'hA5, 4'd1},
        {1'b0, 16'h00FF, 8'h81, 4'd0},
        {1'b1, 16'hFF00, 8'h3C, 4'd3},
        {1'b1, 16'h00FF, 8'h81, 4'd0},
        {1'b0, 16'h1234, 8'h5A, 4'd1},
        {1'b1, 16'h1234, 8'h5A, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rw = 1'b1;
    logic        cpu_phi2 = 1'b0;
    logic [7:0]  cpu_din = '0;
    logic [7:0]  cpu_dout;
    logic        cpu_doe;
    logic        cpu_irq_n;
    logic [23:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        bus_wstrb;
    logic        bus_rstrb;
    logic        bus_ready = 1'b0;
    logic        bus_irq = 1'b0;
    logic        path_oe_n;

    int checks = 0;
    int errors = 0;
    logic [7:0] mem [256];

    always #2.5 clk = ~clk;

    cpu_bus_bridge u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
        .cpu_phi2(cpu_phi2), .cpu_din(cpu_din), .cpu_dout(cpu_dout),
        .cpu_doe(cpu_doe), .cpu_irq_n(cpu_irq_n), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wstrb(bus_wstrb),
        .bus_rstrb(bus_rstrb), .bus_ready(bus_ready), .bus_irq(bus_irq),
        .path_oe_n(path_oe_n)
    );

    // target model
    always @(posedge clk) if (bus_wstrb && bus_ready) mem[bus_addr[7:0]] <= bus_wdata;
    assign bus_rdata = bus_rstrb ? mem[bus_addr[7:0]] : 8'h00;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_cycle(input logic rw, input logic [15:0] a, input logic [7:0] d,
                             input int dly);
        @(negedge clk);
        cpu_addr = a; cpu_rw = rw; cpu_din = rw ? 8'hEE : d; cpu_phi2 = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R2 idle before sync", {31'd0, path_oe_n}, 1);
        @(posedge clk); @(negedge clk);
        chk("R5 enable in DRIVE", {31'd0, path_oe_n}, 0);
        chk("R10 address", {8'd0, bus_addr}, {8'd0, SLOT, a});
        if (rw) chk("R6 rstrb DRIVE", {30'd0, bus_rstrb, bus_wstrb}, 2);
        else begin
            chk("R7 wstrb DRIVE", {30'd0, bus_rstrb, bus_wstrb}, 1);
            chk("R8 write data", {24'd0, bus_wdata}, {24'd0, d});
        end
        for (int i = 0; i <= dly; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R3 wait hold", {29'd0, path_oe_n, bus_rstrb, bus_wstrb}, rw ? 2 : 1);
        end
        bus_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_ready = 1'b0;
        chk("R7 no wstrb in DONE", {31'd0, bus_wstrb}, 0);
        chk("R5 enable in DONE", {31'd0, path_oe_n}, 0);
        chk("R10 address in DONE", {8'd0, bus_addr}, {8'd0, SLOT, a});
        if (rw) begin
            chk("R6 rstrb DONE", {31'd0, bus_rstrb}, 1);
            chk("R9 read data", {23'd0, cpu_doe, cpu_dout}, {23'd0, 1'b1, d});
        end else chk("R9 no drive on write", {31'd0, cpu_doe}, 0);
        repeat (2) begin
            @(posedge clk); @(negedge clk);
            chk("R4 DONE holds", {31'd0, path_oe_n}, 0);
            if (rw) chk("R9 read data held", {24'd0, cpu_dout}, {24'd0, d});
        end
        cpu_phi2 = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R4 DONE until sync low", {31'd0, path_oe_n}, 0);
        @(posedge clk); @(negedge clk);
        chk("R4 back to IDLE", {29'd0, path_oe_n, bus_rstrb, bus_wstrb}, 4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset outputs", {29'd0, path_oe_n, bus_rstrb, bus_wstrb}, 4);
        chk("R1 reset address", {8'd0, bus_addr}, 0);
        chk("R1 reset data", {23'd0, cpu_doe, bus_wdata}, 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 idle after reset", {31'd0, path_oe_n}, 1);

        for (int v = 0; v < NVEC; v++) begin
            run_cycle(VEC[v][28], VEC[v][27:12], VEC[v][11:4], int'(VEC[v][3:0]));
        end

        // R12: ready while idle does nothing
        @(negedge clk); bus_ready = 1'b1;
        repeat (5) begin
            @(posedge clk); @(negedge clk);
            chk("R12 ready ignored in IDLE", {29'd0, path_oe_n, bus_rstrb, bus_wstrb}, 4);
        end
        bus_ready = 1'b0;

        // R11: interrupt inversion
        bus_irq = 1'b1; #1;
        chk("R11 irq asserted", {31'd0, cpu_irq_n}, 0);
        bus_irq = 1'b0; #1;
        chk("R11 irq released", {31'd0, cpu_irq_n}, 1);

        // reset mid-transaction returns to IDLE (R1)
        @(negedge clk); cpu_rw = 1'b0; cpu_phi2 = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 wstrb before reset", {31'd0, bus_wstrb}, 1);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 reset mid-cycle", {29'd0, path_oe_n, bus_rstrb, bus_wstrb}, 4);
        rst_n = 1'b1; cpu_phi2 = 1'b0;
        repeat (3) @(posedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule